// File: doc/BRIEF.md
# Segmented Instruction Pointer Unit

This block holds the code segment and the instruction offset of a segmented 16-bit processor. It forms the 20-bit physical fetch address from them every cycle. On each clock edge it applies at most one control operation: a sequential advance by the length of the finished instruction, a near jump or call, a far jump or call, an interrupt entry, or a return.

Calls and interrupt entries present a return frame for a stack outside the block. The frame appears as a registered pulse one cycle after the operation, and it holds the segment and the offset the return must restore. A return takes the frame back on its pop inputs and reloads the offset, or the offset and the segment when the frame is far.

When several operation requests are raised in the same cycle, a fixed priority picks one. Instruction decode, the stack memory, bus access and prefetching lie outside this block.

Top module: `seg_ip_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the registers take segment 16'hFFFF and offset 16'h0000. The fetch address is then 20'hFFFF0 and `push_valid` is 0.
- R2: `fetch_addr` always equals (`cs_out` × 16 + `ip_out`) modulo 2^20. A segment of FFFF with an offset of FFFF gives 0FFEF.
- R3: An advance with a length of 1 to 6 adds that length to the offset modulo 2^16. The segment keeps its value, and no carry reaches it when the offset wraps.
- R4: An advance with `instr_len` of 0 leaves both registers unchanged.
- R5: A near operation loads `near_ofs` into the offset and leaves the segment unchanged.
- R6: A far operation loads `far_seg` and `far_ofs` into the segment and the offset in the same edge.
- R7: A near operation with `link` high is a near call. In the next cycle `push_valid` is 1 and `push_far` is 0. `push_ofs` equals the old offset plus `instr_len` modulo 2^16, and `push_seg` equals the old segment.
- R8: A far operation with `link` high is a far call. In the next cycle `push_valid` and `push_far` are 1. `push_seg` holds the old segment and `push_ofs` holds the old offset plus `instr_len`.
- R9: An interrupt entry loads `irq_seg` and `irq_ofs`. In the next cycle it pushes a far frame with the old segment and the old offset unadvanced.
- R10: A return with `ret_far` low loads only the offset from `pop_ofs`. With `ret_far` high it also loads the segment from `pop_seg`.
- R11: Among simultaneous requests, the priority is interrupt, then far, then near, then return, then advance. Only the winning request takes effect.
- R12: `push_valid` is a single-cycle pulse. It is 0 in any cycle after an edge that accepted no call and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 1 | Interrupt entry request |
| irq_seg | input | 16 | Segment of the interrupt handler |
| irq_ofs | input | 16 | Offset of the interrupt handler |
| far_req | input | 1 | Far jump or call request |
| far_seg | input | 16 | Far target segment |
| far_ofs | input | 16 | Far target offset |
| near_req | input | 1 | Near jump or call request |
| near_ofs | input | 16 | Near target offset |
| link | input | 1 | Makes a near or far operation a call |
| ret_req | input | 1 | Return request |
| ret_far | input | 1 | Return also restores the segment |
| pop_seg | input | 16 | Segment popped for a far return |
| pop_ofs | input | 16 | Offset popped for a return |
| adv_req | input | 1 | Sequential advance request |
| instr_len | input | 3 | Byte length of the current instruction |
| fetch_addr | output | 20 | Physical fetch address |
| cs_out | output | 16 | Current code segment |
| ip_out | output | 16 | Current instruction offset |
| push_valid | output | 1 | Return frame valid, one cycle |
| push_far | output | 1 | Frame carries a segment |
| push_seg | output | 16 | Segment to push |
| push_ofs | output | 16 | Offset to push |

## Verification
Advances with lengths 3, 6 and 0 separate a real step from the no-change case. An advance from FFFE shows that the offset wraps without touching the segment. Near and far jumps, with and without `link`, show whether the segment is reloaded and whether a frame appears. The frame of an interrupt, which carries the unadvanced offset, is compared against that of a call, which carries the offset plus the length. The request sets are then stripped one level at a time, from all five raised down to return with advance, to confirm each priority step. Far targets such as FFFF:FFFF and F000:FFF0 confirm the 20-bit wrap of the address sum.

// File: rtl/segip_pkg.sv
package segip_pkg;

    parameter int SEG_W = 16;
    parameter int OFS_W = 16;
    parameter int LEN_W = 3;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADV,
        OP_RET,
        OP_NEAR,
        OP_FAR,
        OP_IRQ
    } op_e;

    typedef struct packed {
        logic [SEG_W-1:0] cs;
        logic [OFS_W-1:0] ip;
        logic             push_v;
        logic             push_far;
        logic [SEG_W-1:0] push_seg;
        logic [OFS_W-1:0] push_ofs;
    } ptr_state_t;

endpackage

// File: rtl/segip_arbiter.sv
module segip_arbiter
    import segip_pkg::*;
(
    input  logic irq_req,
    input  logic far_req,
    input  logic near_req,
    input  logic ret_req,
    input  logic adv_req,
    output op_e  op
);

    always_comb begin
        if (irq_req)       op = OP_IRQ;
        else if (far_req)  op = OP_FAR;
        else if (near_req) op = OP_NEAR;
        else if (ret_req)  op = OP_RET;
        else if (adv_req)  op = OP_ADV;
        else               op = OP_NONE;
    end

endmodule

// File: rtl/segip_next.sv
module segip_next
    import segip_pkg::*;
(
    input  op_e              op,
    input  ptr_state_t       cur,
    input  logic             link,
    input  logic             ret_far,
    input  logic [LEN_W-1:0] instr_len,
    input  logic [SEG_W-1:0] irq_seg,
    input  logic [OFS_W-1:0] irq_ofs,
    input  logic [SEG_W-1:0] far_seg,
    input  logic [OFS_W-1:0] far_ofs,
    input  logic [OFS_W-1:0] near_ofs,
    input  logic [SEG_W-1:0] pop_seg,
    input  logic [OFS_W-1:0] pop_ofs,
    output ptr_state_t       nxt
);

    logic [OFS_W-1:0] step_ofs_d;

    always_comb begin
        step_ofs_d   = cur.ip + OFS_W'(instr_len);
        nxt          = cur;
        nxt.push_v   = 1'b0;
        nxt.push_far = 1'b0;
        unique case (op)
            OP_IRQ: begin
                nxt.push_v   = 1'b1;
                nxt.push_far = 1'b1;
                nxt.push_seg = cur.cs;
                nxt.push_ofs = cur.ip;
                nxt.cs       = irq_seg;
                nxt.ip       = irq_ofs;
            end
            OP_FAR: begin
                if (link) begin
                    nxt.push_v   = 1'b1;
                    nxt.push_far = 1'b1;
                    nxt.push_seg = cur.cs;
                    nxt.push_ofs = step_ofs_d;
                end
                nxt.cs = far_seg;
                nxt.ip = far_ofs;
            end
            OP_NEAR: begin
                if (link) begin
                    nxt.push_v   = 1'b1;
                    nxt.push_seg = cur.cs;
                    nxt.push_ofs = step_ofs_d;
                end
                nxt.ip = near_ofs;
            end
            OP_RET: begin
                nxt.ip = pop_ofs;
                if (ret_far) nxt.cs = pop_seg;
            end
            OP_ADV: begin
                if (instr_len != '0) nxt.ip = step_ofs_d;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/segip_addr.sv
module segip_addr
    import segip_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int SHIFT  = 4
) (
    input  logic [SEG_W-1:0]  cs,
    input  logic [OFS_W-1:0]  ip,
    output logic [ADDR_W-1:0] addr
);

    localparam int WIDE_W = ((SEG_W + SHIFT) > OFS_W ? (SEG_W + SHIFT) : OFS_W) + 1;

    logic [WIDE_W-1:0] sum_d;

    always_comb begin
        sum_d = (WIDE_W'(cs) << SHIFT) + WIDE_W'(ip);
        addr  = sum_d[ADDR_W-1:0];
    end

endmodule

// File: rtl/seg_ip_unit.sv
module seg_ip_unit
    import segip_pkg::*;
#(
    parameter int               ADDR_W    = 20,
    parameter int               SHIFT     = 4,
    parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
    parameter logic [OFS_W-1:0] RESET_OFS = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic [SEG_W-1:0]  irq_seg,
    input  logic [OFS_W-1:0]  irq_ofs,
    input  logic              far_req,
    input  logic [SEG_W-1:0]  far_seg,
    input  logic [OFS_W-1:0]  far_ofs,
    input  logic              near_req,
    input  logic [OFS_W-1:0]  near_ofs,
    input  logic              link,
    input  logic              ret_req,
    input  logic              ret_far,
    input  logic [SEG_W-1:0]  pop_seg,
    input  logic [OFS_W-1:0]  pop_ofs,
    input  logic              adv_req,
    input  logic [LEN_W-1:0]  instr_len,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [SEG_W-1:0]  cs_out,
    output logic [OFS_W-1:0]  ip_out,
    output logic              push_valid,
    output logic              push_far,
    output logic [SEG_W-1:0]  push_seg,
    output logic [OFS_W-1:0]  push_ofs
);

    op_e        op;
    ptr_state_t state_q;
    ptr_state_t state_d;

    segip_arbiter u_arb (
        .irq_req  (irq_req),
        .far_req  (far_req),
        .near_req (near_req),
        .ret_req  (ret_req),
        .adv_req  (adv_req),
        .op       (op)
    );

    segip_next u_next (
        .op        (op),
        .cur       (state_q),
        .link      (link),
        .ret_far   (ret_far),
        .instr_len (instr_len),
        .irq_seg   (irq_seg),
        .irq_ofs   (irq_ofs),
        .far_seg   (far_seg),
        .far_ofs   (far_ofs),
        .near_ofs  (near_ofs),
        .pop_seg   (pop_seg),
        .pop_ofs   (pop_ofs),
        .nxt       (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q          <= '0;
            state_q.cs       <= RESET_SEG;
            state_q.ip       <= RESET_OFS;
        end else begin
            state_q <= state_d;
        end
    end

    segip_addr #(
        .ADDR_W (ADDR_W),
        .SHIFT  (SHIFT)
    ) u_addr (
        .cs   (state_q.cs),
        .ip   (state_q.ip),
        .addr (fetch_addr)
    );

    assign cs_out     = state_q.cs;
    assign ip_out     = state_q.ip;
    assign push_valid = state_q.push_v;
    assign push_far   = state_q.push_far;
    assign push_seg   = state_q.push_seg;
    assign push_ofs   = state_q.push_ofs;

    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (cs_out == RESET_SEG && ip_out == RESET_OFS && !push_valid));

    p_adv_seg_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADV) |=> (cs_out == $past(cs_out)));

    p_zero_len_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADV && instr_len == '0) |=> $stable(ip_out));

    p_near_seg_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NEAR) |=> (cs_out == $past(cs_out) && ip_out == $past(near_ofs)));

    p_far_load_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_FAR) |=> (cs_out == $past(far_seg) && ip_out == $past(far_ofs)));

    p_near_call_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NEAR && link) |=> (push_valid && !push_far));

    p_irq_frame_r9: assert property (@(posedge clk) disable iff (rst)
        irq_req |=> (push_valid && push_far && push_ofs == $past(ip_out)
                     && push_seg == $past(cs_out) && cs_out == $past(irq_seg)));

    p_near_ret_r10: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RET && !ret_far) |=> (cs_out == $past(cs_out) && ip_out == $past(pop_ofs)));

    p_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADV || op == OP_RET || op == OP_NONE) |=> !push_valid);

endmodule

// File: tb/seg_ip_unit_bench.sv
module seg_ip_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 0, far_req = 0, near_req = 0, ret_req = 0, adv_req = 0;
    logic        link = 0, ret_far = 0;
    logic [15:0] irq_seg = 0, irq_ofs = 0, far_seg = 0, far_ofs = 0;
    logic [15:0] near_ofs = 0, pop_seg = 0, pop_ofs = 0;
    logic [2:0]  instr_len = 0;
    logic [19:0] fetch_addr;
    logic [15:0] cs_out, ip_out, push_seg, push_ofs;
    logic        push_valid, push_far;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    seg_ip_unit u_seg_ip_unit (
        .clk(clk), .rst(rst),
        .irq_req(irq_req), .irq_seg(irq_seg), .irq_ofs(irq_ofs),
        .far_req(far_req), .far_seg(far_seg), .far_ofs(far_ofs),
        .near_req(near_req), .near_ofs(near_ofs), .link(link),
        .ret_req(ret_req), .ret_far(ret_far), .pop_seg(pop_seg), .pop_ofs(pop_ofs),
        .adv_req(adv_req), .instr_len(instr_len),
        .fetch_addr(fetch_addr), .cs_out(cs_out), .ip_out(ip_out),
        .push_valid(push_valid), .push_far(push_far),
        .push_seg(push_seg), .push_ofs(push_ofs)
    );

    typedef struct {
        logic [15:0] cs;
        logic [15:0] ip;
        logic        pv;
        logic        pf;
        logic [15:0] ps;
        logic [15:0] po;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] m_cs = 16'hFFFF;
    logic [15:0] m_ip = 16'h0000;

    function automatic logic [19:0] addr_of(logic [15:0] s, logic [15:0] o);
        return ({4'h0, s} << 4) + {4'h0, o};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        irq_req = 0; far_req = 0; near_req = 0; ret_req = 0; adv_req = 0;
        link = 0; ret_far = 0; instr_len = 0;
    endtask

    // driver: model the accepted operation, wait for the edge, queue the expectation
    task automatic fire(string tag);
        exp_t e;
        logic [15:0] nxt_ofs;
        nxt_ofs = m_ip + 16'(instr_len);
        e.pv = 0; e.pf = 0; e.ps = 0; e.po = 0; e.tag = tag;
        if (irq_req) begin
            e.pv = 1; e.pf = 1; e.ps = m_cs; e.po = m_ip;
            m_cs = irq_seg; m_ip = irq_ofs;
        end else if (far_req) begin
            if (link) begin e.pv = 1; e.pf = 1; e.ps = m_cs; e.po = nxt_ofs; end
            m_cs = far_seg; m_ip = far_ofs;
        end else if (near_req) begin
            if (link) begin e.pv = 1; e.pf = 0; e.ps = m_cs; e.po = nxt_ofs; end
            m_ip = near_ofs;
        end else if (ret_req) begin
            m_ip = pop_ofs;
            if (ret_far) m_cs = pop_seg;
        end else if (adv_req) begin
            m_ip = nxt_ofs;
        end
        e.cs = m_cs; e.ip = m_ip;
        @(posedge clk);
        #1;
        sb_q.push_back(e);
        idle();
    endtask

    // monitor
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, "cs", 32'(cs_out), 32'(e.cs));
            check(e.tag, "ip", 32'(ip_out), 32'(e.ip));
            check({e.tag, "/R2"}, "fetch", 32'(fetch_addr), 32'(addr_of(e.cs, e.ip)));
            check(e.tag, "push_valid", 32'(push_valid), 32'(e.pv));
            if (e.pv) begin
                check(e.tag, "push_far", 32'(push_far), 32'(e.pf));
                check(e.tag, "push_seg", 32'(push_seg), 32'(e.ps));
                check(e.tag, "push_ofs", 32'(push_ofs), 32'(e.po));
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "cs", 32'(cs_out), 32'hFFFF);
        check("R1", "ip", 32'(ip_out), 32'h0000);
        check("R1", "fetch", 32'(fetch_addr), 32'hFFFF0);
        check("R1", "push_valid", 32'(push_valid), 32'h0);
        @(posedge clk); #1;
        rst = 0;

        adv_req = 1; instr_len = 3; fire("R3 len3");
        adv_req = 1; instr_len = 6; fire("R3 len6");
        adv_req = 1; instr_len = 0; fire("R4 len0");
        near_req = 1; near_ofs = 16'hFFFE; fire("R5 near");
        adv_req = 1; instr_len = 5; fire("R3 wrap");
        far_req = 1; far_seg = 16'h1234; far_ofs = 16'h5678; fire("R6 far");
        far_req = 1; far_seg = 16'hFFFF; far_ofs = 16'hFFFF; fire("R2 wrap20");
        far_req = 1; far_seg = 16'hF000; far_ofs = 16'hFFF0; fire("R6 far2");
        near_req = 1; link = 1; instr_len = 3; near_ofs = 16'h0100; fire("R7 near call");
        idle(); fire("R12 idle");
        far_req = 1; link = 1; instr_len = 5; far_seg = 16'h2000; far_ofs = 16'h0010; fire("R8 far call");
        adv_req = 1; instr_len = 2; fire("R12 adv");
        irq_req = 1; instr_len = 4; irq_seg = 16'h0040; irq_ofs = 16'h0200; fire("R9 irq");
        ret_req = 1; ret_far = 0; pop_seg = 16'hAAAA; pop_ofs = 16'h0300; fire("R10 near ret");
        ret_req = 1; ret_far = 1; pop_seg = 16'h3000; pop_ofs = 16'h0044; fire("R10 far ret");
        irq_req = 1; far_req = 1; near_req = 1; ret_req = 1; adv_req = 1; link = 1; instr_len = 1;
        irq_seg = 16'h0011; irq_ofs = 16'h0022; far_seg = 16'h0033; far_ofs = 16'h0044;
        near_ofs = 16'h0055; pop_seg = 16'h0066; pop_ofs = 16'h0077; fire("R11 irq wins");
        far_req = 1; near_req = 1; ret_req = 1; adv_req = 1; instr_len = 1; fire("R11 far wins");
        near_req = 1; ret_req = 1; adv_req = 1; instr_len = 1; fire("R11 near wins");
        ret_req = 1; ret_far = 1; adv_req = 1; instr_len = 1; fire("R11 ret wins");
        fire("R12 final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule